// File: doc/BRIEF.md
# Bit-Set / Bit-Clear Aliased Control Register Bank

This block holds a small bank of control registers for a peripheral sitting on a simple word-addressed bus. Each register can be reached at three neighbouring word addresses. A write to the first address turns on every bit that carries a 1 in the write data. A write to the second address turns off every bit that carries a 1. A read of the third address returns the stored value. Software can therefore change one flag without a read-modify-write sequence, and an interrupt handler cannot undo a change made by another thread.

The bank answers only inside its own address window. The window starts at a base address aligned to its own size. A parameter sets the window size: 16 KB by default, and a narrower 4 KB window is available for a controller that needs less room. Inside the window, register k uses word offsets 3k (set), 3k+1 (clear) and 3k+2 (read). The peripheral logic can also raise bits from its side through a per-register event input. Every register is driven onto a parallel output that the peripheral function consumes.

Top module: `acr_bank`

## Requirements
- R1: While reset (rst_n low) is asserted, every register bit and the read data output are zero.
- R2: A write at word offset 3k of the window sets each bit of register k where the write data is 1, and leaves each bit where it is 0 unchanged.
- R3: A write at word offset 3k+1 clears each bit of register k where the write data is 1, and leaves each bit where it is 0 unchanged.
- R4: A read strobe at word offset 3k+2 loads the value of register k into the read data output, which shows it from the clock edge that takes the strobe. With no read strobe the read data output holds its last value.
- R5: A read strobe at a set or clear address loads zero into the read data output.
- R6: A write at a read address changes no register.
- R7: An access hits the bank only when address bits [ADDR_W-1:WIN_LOG2] equal those of BASE_ADDR. The base is the lowest address in the window. Writes outside the window are ignored, and reads outside it load zero.
- R8: Word offsets at or above 3*NUM_REGS inside the window are unmapped. Writes there are ignored, and reads there load zero.
- R9: A 1 on the event-set input of register k sets that bit. When a bus clear hits the same bit in the same cycle, the clear wins.
- R10: A read returns the register value from before the clock edge that takes the strobe, so an update at that same edge does not show in that read.
- R11: Address bits [1:0] do not affect decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| addr_i | input | ADDR_W | Byte address of the bus access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data, a bit mask for the set and clear aliases |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Registered read data |
| evt_set_i | input | NUM_REGS*DATA_W | Peripheral-side bit-set requests, register k in slice k |
| regs_o | output | NUM_REGS*DATA_W | Stored register values, register k in slice k |

## Verification
The bench builds the bank with three 16-bit registers, a 20-bit address and the narrow 4 KB window (WIN_LOG2 = 12). This puts the unmapped word offsets from 9 upward inside the window. It also brings both neighbouring windows within a few address steps of the base. A set, clear or read can then land just outside the window, on an unmapped word, or on a wrong alias. Collisions between peripheral events and bus clears are driven on purpose. Random mixed traffic then compares every register and the read data against a behavioural model on each clock.

// File: rtl/acr_pkg.sv
package acr_pkg;

  // Which of the three aliases an access addresses.
  typedef enum logic [1:0] {
    ALIAS_SET  = 2'd0,
    ALIAS_CLR  = 2'd1,
    ALIAS_RD   = 2'd2,
    ALIAS_NONE = 2'd3
  } alias_e;

  // Number of word addresses each register occupies.
  localparam int unsigned ALIASES_PER_REG = 3;

endpackage

// File: rtl/acr_win_dec.sv
module acr_win_dec #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WIN_LOG2  = 14,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  localparam int unsigned OFF_W    = WIN_LOG2 - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [OFF_W-1:0]  word_off_o
);

  logic unused_byte_lane;

  // Window match on the bits above the window size; base is window-aligned.
  assign hit_o      = (addr_i[ADDR_W-1:WIN_LOG2] == BASE_ADDR[ADDR_W-1:WIN_LOG2]);
  assign word_off_o = addr_i[WIN_LOG2-1:2];
  assign unused_byte_lane = ^addr_i[1:0];

endmodule

// File: rtl/acr_alias_dec.sv
module acr_alias_dec
  import acr_pkg::*;
#(
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit_i,
  input  logic [OFF_W-1:0]    word_off_i,
  output logic [NUM_REGS-1:0] sel_o,
  output alias_e              kind_o
);

  logic [NUM_REGS-1:0] set_hit;
  logic [NUM_REGS-1:0] clr_hit;
  logic [NUM_REGS-1:0] rd_hit;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_match
    localparam int unsigned SET_OFF = ALIASES_PER_REG * k;
    assign set_hit[k] = hit_i && (word_off_i == OFF_W'(SET_OFF));
    assign clr_hit[k] = hit_i && (word_off_i == OFF_W'(SET_OFF + 1));
    assign rd_hit[k]  = hit_i && (word_off_i == OFF_W'(SET_OFF + 2));
  end

  always_comb begin
    sel_o  = '0;
    kind_o = ALIAS_NONE;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (set_hit[k]) begin
        sel_o[k] = 1'b1;
        kind_o   = ALIAS_SET;
      end else if (clr_hit[k]) begin
        sel_o[k] = 1'b1;
        kind_o   = ALIAS_CLR;
      end else if (rd_hit[k]) begin
        sel_o[k] = 1'b1;
        kind_o   = ALIAS_RD;
      end
    end
  end

  // R8
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));

  // R7
  dec_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_i |-> (sel_o == '0 && kind_o == ALIAS_NONE));

endmodule

// File: rtl/acr_bit_reg.sv
module acr_bit_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] q_d;
  logic              q_en;

  always_comb begin
    q_en = |(set_i | clr_i);
    q_d  = (q_o | set_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else if (q_en) begin
      q_o <= q_d;
    end
  end

  // R3
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((q_o & $past(clr_i)) == '0));

  // R2
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & ~clr_i)) |=> ((q_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

  // R2
  idle_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q_o ^ $past(q_o)) & ~$past(set_i | clr_i)) == '0));

endmodule

// File: rtl/acr_rd_port.sv
module acr_rd_port
  import acr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en_i,
  input  logic [NUM_REGS-1:0]        sel_i,
  input  alias_e                     kind_i,
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]          rdata_o
);

  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (kind_i == ALIAS_RD) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (sel_i[k]) rd_d = regs_i[k*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
    end else if (rd_en_i) begin
      rdata_o <= rd_d;
    end
  end

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));

  // R5
  rd_alias_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && kind_i != ALIAS_RD) |=> (rdata_o == '0));

endmodule

// File: rtl/acr_bank.sv
module acr_bank
  import acr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned WIN_LOG2  = 14,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFA_0000,
  localparam int unsigned OFF_W    = WIN_LOG2 - 2,
  localparam int unsigned BANK_W   = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [BANK_W-1:0] evt_set_i,
  output logic [BANK_W-1:0] regs_o
);

  logic                win_hit;
  logic [OFF_W-1:0]    word_off;
  logic [NUM_REGS-1:0] sel;
  alias_e              kind;
  logic                wr_set;
  logic                wr_clr;

  acr_win_dec #(
    .ADDR_W    (ADDR_W),
    .WIN_LOG2  (WIN_LOG2),
    .BASE_ADDR (BASE_ADDR)
  ) win_dec_i (
    .addr_i     (addr_i),
    .hit_o      (win_hit),
    .word_off_o (word_off)
  );

  acr_alias_dec #(
    .OFF_W    (OFF_W),
    .NUM_REGS (NUM_REGS)
  ) alias_dec_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (win_hit),
    .word_off_i (word_off),
    .sel_o      (sel),
    .kind_o     (kind)
  );

  assign wr_set = wr_en_i && (kind == ALIAS_SET);
  assign wr_clr = wr_en_i && (kind == ALIAS_CLR);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] clr_mask;

    always_comb begin
      set_mask = evt_set_i[k*DATA_W +: DATA_W];
      clr_mask = '0;
      if (sel[k] && wr_set) set_mask = set_mask | wdata_i;
      if (sel[k] && wr_clr) clr_mask = wdata_i;
    end

    acr_bit_reg #(
      .DATA_W (DATA_W)
    ) reg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_mask),
      .clr_i (clr_mask),
      .q_o   (regs_o[k*DATA_W +: DATA_W])
    );
  end

  acr_rd_port #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) rd_port_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en_i (rd_en_i),
    .sel_i   (sel),
    .kind_i  (kind),
    .regs_i  (regs_o),
    .rdata_o (rdata_o)
  );

  // R6
  rd_alias_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && kind == ALIAS_RD && evt_set_i == '0) |=> $stable(regs_o));

  // R7
  outside_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !win_hit) |=> (rdata_o == '0));

  // R7
  outside_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !win_hit && evt_set_i == '0) |=> $stable(regs_o));

endmodule

// File: tb/acr_bank_tb.sv
`timescale 1ns/1ps
module acr_bank_tb_top;

  localparam int unsigned AW = 20;
  localparam int unsigned DW = 16;
  localparam int unsigned NR = 3;
  localparam int unsigned WL = 12;
  localparam logic [AW-1:0] BASE = 20'h4_3000;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          wr_en;
  logic [DW-1:0] wdata;
  logic          rd_en;
  logic [DW-1:0] rdata;
  logic [NR*DW-1:0] evt;
  logic [NR*DW-1:0] regs;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] m [NR];
  logic [DW-1:0] exp_rd;

  acr_bank #(
    .ADDR_W (AW), .DATA_W (DW), .NUM_REGS (NR), .WIN_LOG2 (WL), .BASE_ADDR (BASE)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .addr_i (addr), .wr_en_i (wr_en), .wdata_i (wdata),
    .rd_en_i (rd_en), .rdata_o (rdata), .evt_set_i (evt), .regs_o (regs)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic compare(input string tag);
    checks++;
    for (int k = 0; k < NR; k++) begin
      if (regs[k*DW +: DW] !== m[k]) begin
        errors++;
        $display("FAIL %s reg%0d actual %h expected %h", tag, k, regs[k*DW +: DW], m[k]);
      end
    end
    if (rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s rdata actual %h expected %h", tag, rdata, exp_rd);
    end
  endtask

  // One bus cycle: drive, let the edge pass, update the model, check at negedge.
  task automatic cyc(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                     input logic r, input logic [NR*DW-1:0] e, input string tag);
    bit          hit;
    int unsigned off;
    int unsigned idx;
    int unsigned kind;
    logic [DW-1:0] rv;
    addr = a; wr_en = w; wdata = d; rd_en = r; evt = e;
    @(posedge clk);
    hit  = ((a >> WL) == (BASE >> WL));
    off  = (a & ((1 << WL) - 1)) >> 2;
    idx  = off / 3;
    kind = off % 3;
    if (!hit || off >= 3 * NR) kind = 3;
    rv = '0;
    if (kind == 2) rv = m[idx];
    if (r) exp_rd = rv;
    for (int k = 0; k < NR; k++) begin
      logic [DW-1:0] s;
      logic [DW-1:0] c;
      s = e[k*DW +: DW];
      c = '0;
      if (w && kind == 0 && idx == k) s = s | d;
      if (w && kind == 1 && idx == k) c = d;
      m[k] = (m[k] | s) & ~c;
    end
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [AW-1:0] adr(input int reg_i, input int alias_i);
    return BASE + AW'(12 * reg_i + 4 * alias_i);
  endfunction

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 0; wdata = '0; rd_en = 0; evt = '0;
    for (int k = 0; k < NR; k++) m[k] = '0;
    exp_rd = '0;
    // R1: reset state, even with strobes active
    @(negedge clk);
    wr_en = 1; addr = adr(0, 0); wdata = 16'hFFFF; rd_en = 1; evt = '1;
    @(negedge clk);
    compare("R1");
    wr_en = 0; rd_en = 0; evt = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: set alias, zero bits keep state
    cyc(adr(0, 0), 1, 16'h00F0, 0, '0, "R2");
    cyc(adr(0, 0), 1, 16'h0003, 0, '0, "R2");
    cyc(adr(2, 0), 1, 16'hA5A5, 0, '0, "R2");
    cyc(adr(0, 0), 1, 16'h0000, 0, '0, "R2");
    // R4: read alias, registered and held
    cyc(adr(0, 2), 0, '0, 1, '0, "R4");
    cyc(adr(2, 2), 0, '0, 0, '0, "R4");
    cyc(adr(2, 2), 0, '0, 1, '0, "R4");
    cyc(adr(1, 2), 0, '0, 0, '0, "R4");
    // R3: clear alias
    cyc(adr(0, 1), 1, 16'h0011, 0, '0, "R3");
    cyc(adr(2, 1), 1, 16'h0000, 0, '0, "R3");
    cyc(adr(0, 2), 0, '0, 1, '0, "R3");
    // R5: set/clear aliases read zero
    cyc(adr(2, 0), 0, '0, 1, '0, "R5");
    cyc(adr(0, 2), 0, '0, 1, '0, "R5");
    cyc(adr(0, 1), 0, '0, 1, '0, "R5");
    // R6: write to read alias ignored
    cyc(adr(1, 2), 1, 16'hFFFF, 0, '0, "R6");
    cyc(adr(2, 2), 1, 16'h0000, 0, '0, "R6");
    cyc(adr(1, 2), 0, '0, 1, '0, "R6");
    // R7: window edges
    cyc(BASE + 20'h1000, 1, 16'hFFFF, 0, '0, "R7");
    cyc(BASE - 20'h1000 + 20'h4, 1, 16'hFFFF, 0, '0, "R7");
    cyc(adr(0, 2), 0, '0, 1, '0, "R7");
    cyc(BASE - 20'h1000 + 20'h8, 0, '0, 1, '0, "R7");
    cyc(BASE, 1, 16'h8000, 0, '0, "R7");
    // R8: unmapped word offsets
    cyc(BASE + 20'd36, 1, 16'hFFFF, 0, '0, "R8");
    cyc(BASE + 20'hFFC, 1, 16'hFFFF, 0, '0, "R8");
    cyc(adr(2, 2), 0, '0, 1, '0, "R8");
    cyc(BASE + 20'd44, 0, '0, 1, '0, "R8");
    // R9: event set, clear wins on collision
    cyc(BASE + 20'd36, 0, '0, 0, {16'h0000, 16'h0F00, 16'h0000}, "R9");
    cyc(adr(2, 1), 1, 16'h000F, 0, {16'h00FF, 16'h0000, 16'h0000}, "R9");
    cyc(adr(1, 1), 1, 16'h0300, 0, {16'h0000, 16'h0300, 16'h0001}, "R9");
    // R10: read sees pre-edge value
    cyc(adr(1, 2), 0, '0, 1, {16'h0000, 16'h0001, 16'h0000}, "R10");
    cyc(adr(2, 2), 1, 16'h1234, 1, {16'hFFFF, 16'h0000, 16'h0000}, "R10");
    // R11: byte lane bits ignored
    cyc(adr(0, 1) + 20'd3, 1, 16'hFFFF, 0, '0, "R11");
    cyc(adr(0, 0) + 20'd2, 1, 16'h0C00, 0, '0, "R11");
    cyc(adr(0, 2) + 20'd1, 0, '0, 1, '0, "R11");

    // Mixed traffic against the model (R2 R3 R4 R9)
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [NR*DW-1:0] e;
      int pick;
      pick = $urandom_range(0, 9);
      if (pick < 8) a = BASE + AW'(4 * $urandom_range(0, 10)) + AW'($urandom_range(0, 3));
      else if (pick == 8) a = BASE + 20'h1000 + AW'(4 * $urandom_range(0, 8));
      else a = BASE - 20'h1000 + AW'(4 * $urandom_range(0, 8));
      e = '0;
      if ($urandom_range(0, 3) == 0) e[$urandom_range(0, NR*DW-1)] = 1'b1;
      cyc(a, 1'($urandom_range(0, 1)), DW'($urandom), 1'($urandom_range(0, 1)), e, "MIX");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule